// File: doc/BRIEF.md
# Polled Byte Input Port with Four-Phase Handshake

This block takes bytes from an external device and hands them to a processor that polls for them. On the device side a four-phase valid/accept handshake moves one byte at a time. The device puts a byte on its data lines and raises valid. The port captures the byte and raises accept. The device then lowers valid, and the port lowers accept to close the cycle. The valid line is asynchronous to the port clock, so it passes through a synchronizer of configurable depth before any logic uses it.

On the processor side the port has two addresses behind a single select. Address 0 returns the captured byte, and reading it clears the ready flag. Address 1 returns a status word, and writes to the same address clear status bits. The ready flag also gates the device handshake. While an unread byte is held, the port does not accept a new one, so the device waits with valid high. A device that withdraws an offered byte before the port accepts it has lost that byte. The port records this in a sticky overrun bit. An optional request output follows the ready flag, so the port can also signal an interrupt.

Top module: `pio_hs_port`

## Requirements
- R1: After reset, dev_accept is 0, irq is 0 and the status word read at address 1 is 0.
- R2: When dev_valid is driven high with the ready flag clear, dev_accept rises on the SYNC_STAGES+1-th rising clock edge. At that edge the byte on dev_data is captured and status bit 0 (ready flag) becomes 1.
- R3: When dev_valid falls while dev_accept is high, dev_accept falls on the SYNC_STAGES+1-th rising clock edge after the fall.
- R4: A read at address 0 (bus_sel=1, bus_rd=1, bus_addr=0) returns the captured byte on bus_rdata in the same cycle. The ready flag is 0 from the following clock edge.
- R5: A write at address 1 with bus_wdata bit 0 equal to 1 clears the ready flag. A write at address 1 with bit 0 equal to 0 leaves the flag unchanged.
- R6: While the ready flag is set, a high dev_valid is not accepted. dev_accept stays 0 and the held byte is not overwritten. After the flag clears, the pending byte is accepted.
- R7: If dev_valid falls while dev_accept is still 0, status bit 1 (overrun) becomes 1 and stays 1 until a write at address 1 with bus_wdata bit 1 equal to 1. Reads and flag clears do not change it.
- R8: With USE_IRQ=1, irq equals the ready flag.
- R9: A read or write with bus_sel=0 has no effect on the ready flag or the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_data | input | DATA_W | Byte offered by the device, stable while dev_valid is high |
| dev_valid | input | 1 | Device data-valid, asynchronous |
| dev_accept | output | 1 | Port data-accepted |
| bus_sel | input | 1 | Port select from the address decoder |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the data register, 1 selects status/control |
| bus_wdata | input | DATA_W | Write data; bit 0 clears the ready flag, bit 1 clears overrun |
| bus_rdata | output | DATA_W | Read data: the byte at address 0, {0, overrun, ready} at address 1 |
| irq | output | 1 | Request output that follows the ready flag when enabled |

## Verification
The bench builds the port with DATA_W=8, SYNC_STAGES=2 and USE_IRQ=1. With these values the accept latency is exactly three edges, which the bench measures after both the rise and the fall of valid. The request output can be compared against the ready flag. Holding valid while a byte is unread tests back-pressure. Withdrawing valid before acceptance, then clearing the flag and the overrun bit separately, tests that the overrun bit stays set until it is cleared on its own.

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit USE_IRQ     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_valid,
  output logic              dev_accept,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   valid_s, valid_d;
  logic [DATA_W-1:0]      hold_q;
  logic                   ready_q, ovr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], dev_valid};

  assign valid_s = sync_q[SYNC_STAGES-1];

  wire rd_data  = bus_sel && bus_rd && !bus_addr;
  wire wr_ctrl  = bus_sel && bus_wr &&  bus_addr;
  wire clr_rdy  = rd_data || (wr_ctrl && bus_wdata[0]);
  wire clr_ovr  = wr_ctrl && bus_wdata[1];
  wire take     = valid_s && !dev_accept && !ready_q;
  wire withdraw = valid_d && !valid_s && !dev_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_d    <= 1'b0;
      dev_accept <= 1'b0;
      ready_q    <= 1'b0;
      ovr_q      <= 1'b0;
      hold_q     <= '0;
    end else begin
      valid_d <= valid_s;
      if (take) begin
        hold_q     <= dev_data;
        dev_accept <= 1'b1;
        ready_q    <= 1'b1;
      end else begin
        if (dev_accept && !valid_s) dev_accept <= 1'b0;
        if (clr_rdy)                ready_q    <= 1'b0;
      end
      if (withdraw)     ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
    end
  end

  assign bus_rdata = bus_addr ? {{(DATA_W-2){1'b0}}, ovr_q, ready_q} : hold_q;

  generate
    if (USE_IRQ) begin : g_irq
      assign irq = ready_q;
    end else begin : g_noirq
      assign irq = 1'b0;
    end
  endgenerate

  AST_ACCEPT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_accept) |-> $past(valid_s)) else $error("accept without valid"); // R2

  AST_DROP_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_accept && !valid_s) |=> !dev_accept) else $error("accept held"); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && ready_q) |=> !ready_q) else $error("read kept flag"); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[0] && ready_q) |=> !ready_q) else $error("w1c kept flag"); // R5

  AST_NO_ACCEPT_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !dev_accept) |=> !dev_accept) else $error("accepted while full"); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q) else $error("overrun lost"); // R7

endmodule

// File: tb/pio_hs_port_bench.sv
module pio_hs_port_bench;
  localparam int DW = 8;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] dev_data = '0;
  logic          dev_valid = 1'b0;
  logic          dev_accept;
  logic          bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pio_hs_port #(.DATA_W(DW), .SYNC_STAGES(SS), .USE_IRQ(1'b1)) u_pio_hs_port (
    .clk(clk), .rst_n(rst_n), .dev_data(dev_data), .dev_valid(dev_valid),
    .dev_accept(dev_accept), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, input logic sel, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic wait_accept(input logic lvl, output int n);
    n = 0;
    while (dev_accept !== lvl && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic dev_put(input logic [DW-1:0] b, output int n);
    @(negedge clk);
    dev_data = b; dev_valid = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (dev_accept !== 1'b1 && n < 20);
  endtask

  task automatic dev_drop(output int n);
    @(negedge clk);
    dev_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (dev_accept !== 1'b0 && n < 20);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    check("R1 accept", dev_accept, 0);
    check("R1 irq", irq, 0);
    bus_read(1'b1, 1'b1, d);
    check("R1 status", d, 0);
  endtask

  task automatic t_basic;
    int n; logic [DW-1:0] d;
    dev_put(8'hA5, n);
    check("R2 accept latency", n, SS + 1);
    bus_read(1'b1, 1'b1, d);
    check("R2 status ready", d, 1);
    check("R8 irq set", irq, 1);
    dev_drop(n);
    check("R3 release latency", n, SS + 1);
    bus_read(1'b0, 1'b1, d);
    check("R4 data", d, 8'hA5);
    bus_read(1'b1, 1'b1, d);
    check("R4 flag cleared", d, 0);
    check("R8 irq clear", irq, 0);
  endtask

  task automatic t_w1c;
    int n; logic [DW-1:0] d;
    dev_put(8'h3C, n); dev_drop(n);
    bus_write(1'b1, 1'b1, 8'h00);
    bus_read(1'b1, 1'b1, d);
    check("R5 zero write keeps flag", d, 1);
    bus_write(1'b1, 1'b1, 8'h01);
    bus_read(1'b1, 1'b1, d);
    check("R5 w1c clears flag", d, 0);
  endtask

  task automatic t_hold;
    int n; logic [DW-1:0] d;
    dev_put(8'h11, n); dev_drop(n);
    @(negedge clk);
    dev_data = 8'h22; dev_valid = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 no accept while full", dev_accept, 0);
    bus_read(1'b0, 1'b1, d);
    check("R6 old byte kept", d, 8'h11);
    wait_accept(1'b1, n);
    check("R6 pending accepted", dev_accept, 1);
    dev_drop(n);
    bus_read(1'b0, 1'b1, d);
    check("R6 new byte", d, 8'h22);
    bus_read(1'b1, 1'b1, d);
    check("R6 no overrun", d, 0);
  endtask

  task automatic t_nosel;
    int n; logic [DW-1:0] d;
    dev_put(8'h44, n); dev_drop(n);
    bus_read(1'b0, 1'b0, d);
    bus_write(1'b1, 1'b0, 8'h03);
    bus_read(1'b1, 1'b1, d);
    check("R9 unselected access ignored", d, 1);
    bus_read(1'b0, 1'b1, d);
    check("R9 data intact", d, 8'h44);
  endtask

  task automatic t_ovr;
    int n; logic [DW-1:0] d;
    dev_put(8'h55, n); dev_drop(n);
    @(negedge clk);
    dev_data = 8'h66; dev_valid = 1'b1;
    repeat (4) @(negedge clk);
    dev_valid = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(1'b1, 1'b1, d);
    check("R7 overrun set", d, 3);
    bus_read(1'b0, 1'b1, d);
    check("R7 held byte", d, 8'h55);
    bus_read(1'b1, 1'b1, d);
    check("R7 overrun sticky", d, 2);
    check("R7 withdrawn not accepted", dev_accept, 0);
    bus_write(1'b1, 1'b1, 8'h02);
    bus_read(1'b1, 1'b1, d);
    check("R7 overrun cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_w1c;
    t_hold;
    t_nosel;
    t_ovr;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule